// File: doc/BRIEF.md
# Leaf Interrupt Status Unit

The unit gathers three error events raised by one module: a bad-CRC packet, a bad-length packet and an uncorrectable ECC error. Each event sets a sticky status bit. Software reads the status word and clears individual bits by writing ones to them. Two separate enable words filter the same latched bits. One produces a summary interrupt line and the other produces a summary halt line. With the reset values, the two packet errors interrupt and only the ECC error halts.

When an ECC error is recorded, the ID of the bus master that was active at that time is saved in a 4-bit field of the status word. The field then keeps that value, and later ECC errors do not change it, until software clears it with a write-one-to-clear. The field is information only and never drives either summary line.

Access is through a plain register port. A write is one cycle with `cfg_we_i` high. Reads are combinational from the offset. The reset is asynchronous and active low.

Top module: `leaf_irq_unit`

## Requirements
- R1: After reset, the status word at offset 0x0 reads 0, the interrupt-enable word at 0x4 reads 0x3, the halt-enable word at 0x8 reads 0x4, and `irq_o` and `halt_o` are low.
- R2: An event input that is high at a clock edge sets its status bit: crc is bit 0, len is bit 1, ecc is bit 2. The bit can be read from the next cycle on, and it stays set after the input falls.
- R3: A write to offset 0x0 clears each status event bit whose data bit is 1. Data bits that are 0 leave the matching status bit unchanged.
- R4: If an event and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R5: `irq_o` is high exactly when some status bit [2:0] is set and its bit in the interrupt-enable word (offset 0x4) is also set.
- R6: `halt_o` is high exactly when some status bit [2:0] is set and its bit in the halt-enable word (offset 0x8) is also set.
- R7: A write to 0x4 or 0x8 loads data bits [2:0] into that enable word. The upper bits of either word always read 0.
- R8: An ECC event loads `bus_master_i` into status bits [7:4] when the field is not holding a value. While it holds a value, further ECC events leave bits [7:4] unchanged.
- R9: A write to 0x0 with any of data bits [7:4] set clears the master-ID field to 0 and re-arms it. An ECC event in that same cycle captures the new master ID.
- R10: A read from any offset other than 0x0, 0x4 or 0x8 returns 0. A write to such an offset changes no register.
- R11: The master-ID field affects neither `irq_o` nor `halt_o`. With all event bits clear and all enables set, both lines stay low even while the field holds a nonzero ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crc_err_i | input | 1 | CRC error event, sampled each edge |
| len_err_i | input | 1 | Length error event, sampled each edge |
| ecc_err_i | input | 1 | Uncorrectable ECC error event, sampled each edge |
| bus_master_i | input | ID_W | ID of the bus master active this cycle |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | ADDR_W | Register byte offset |
| cfg_wdata_i | input | DATA_W | Register write data |
| cfg_rdata_o | output | DATA_W | Register read data for `cfg_addr_i` |
| irq_o | output | 1 | Summary interrupt |
| halt_o | output | 1 | Summary halt |

## Verification
The bench builds the unit with its default parameters: 32-bit data, 4-bit offsets and a 4-bit master ID. At this size every combination of latched status pattern, interrupt-enable word and halt-enable word can be swept, 512 cases, with both summary lines predicted arithmetically for each case. The 4-bit offset space also lets the bench probe every unmapped offset. Directed sequences cover the same-cycle set/clear race, the hold and re-arm of the master-ID field, and the independence of the summary lines from that field.

// File: rtl/leaf_irq_pkg.sv
package leaf_irq_pkg;
    localparam int EVT_W   = 3;
    localparam int CRC_BIT = 0;
    localparam int LEN_BIT = 1;
    localparam int ECC_BIT = 2;
    localparam int ID_LSB  = 4;

    localparam int OFS_STAT = 'h0;
    localparam int OFS_IEN  = 'h4;
    localparam int OFS_HEN  = 'h8;

    localparam logic [EVT_W-1:0] IEN_RST = 3'b011;
    localparam logic [EVT_W-1:0] HEN_RST = 3'b100;
endpackage

// File: rtl/leaf_irq_status.sv
module leaf_irq_status
    import leaf_irq_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [EVT_W-1:0] set_i,
    input  logic [EVT_W-1:0] clr_i,
    input  logic [ID_W-1:0]  id_i,
    input  logic             id_clr_i,
    output logic [EVT_W-1:0] evt_o,
    output logic [ID_W-1:0]  id_o,
    output logic             held_o
);
    typedef struct packed {
        logic [EVT_W-1:0] evt;
        logic [ID_W-1:0]  id;
        logic             held;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.evt = (st_q.evt & ~clr_i) | set_i;
        if (id_clr_i) begin
            st_d.id   = '0;
            st_d.held = 1'b0;
        end
        if (set_i[ECC_BIT] && (!st_q.held || id_clr_i)) begin
            st_d.id   = id_i;
            st_d.held = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o  = st_q.evt;
    assign id_o   = st_q.id;
    assign held_o = st_q.held;
endmodule

// File: rtl/leaf_irq_mask.sv
module leaf_irq_mask #(
    parameter int             W   = 3,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] en_o
);
    typedef struct packed {
        logic [W-1:0] en;
    } mask_t;

    mask_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (we_i) begin
            m_d.en = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            m_q.en <= RST;
        end else begin
            m_q <= m_d;
        end
    end

    assign en_o = m_q.en;
endmodule

// File: rtl/leaf_irq_reduce.sv
module leaf_irq_reduce #(
    parameter int W = 3
) (
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] int_en_i,
    input  logic [W-1:0] halt_en_i,
    output logic         irq_o,
    output logic         halt_o
);
    logic [W-1:0] irq_hit;
    logic [W-1:0] halt_hit;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign irq_hit[i]  = src_i[i] & int_en_i[i];
        assign halt_hit[i] = src_i[i] & halt_en_i[i];
    end

    assign irq_o  = |irq_hit;
    assign halt_o = |halt_hit;
endmodule

// File: rtl/leaf_irq_unit.sv
module leaf_irq_unit
    import leaf_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int ID_W   = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              crc_err_i,
    input  logic              len_err_i,
    input  logic              ecc_err_i,
    input  logic [ID_W-1:0]   bus_master_i,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic [DATA_W-1:0] cfg_rdata_o,
    output logic              irq_o,
    output logic              halt_o
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);
    localparam logic [ADDR_W-1:0] A_HEN  = ADDR_W'(OFS_HEN);

    logic             hit_stat, hit_ien, hit_hen;
    logic [EVT_W-1:0] evt_set, evt_clr;
    logic             id_clr;
    logic [EVT_W-1:0] evt_q;
    logic [ID_W-1:0]  id_q;
    logic             held_q;
    logic [EVT_W-1:0] int_en_q, halt_en_q;

    assign hit_stat = (cfg_addr_i == A_STAT);
    assign hit_ien  = (cfg_addr_i == A_IEN);
    assign hit_hen  = (cfg_addr_i == A_HEN);

    always_comb begin
        evt_set          = '0;
        evt_set[CRC_BIT] = crc_err_i;
        evt_set[LEN_BIT] = len_err_i;
        evt_set[ECC_BIT] = ecc_err_i;
    end

    assign evt_clr = (cfg_we_i && hit_stat) ? cfg_wdata_i[EVT_W-1:0] : '0;
    assign id_clr  = cfg_we_i && hit_stat && (|cfg_wdata_i[ID_LSB +: ID_W]);

    leaf_irq_status #(.ID_W(ID_W)) u_status (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (evt_set),
        .clr_i    (evt_clr),
        .id_i     (bus_master_i),
        .id_clr_i (id_clr),
        .evt_o    (evt_q),
        .id_o     (id_q),
        .held_o   (held_q)
    );

    leaf_irq_mask #(.W(EVT_W), .RST(IEN_RST)) u_int_en (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i && hit_ien),
        .wdata_i (cfg_wdata_i[EVT_W-1:0]),
        .en_o    (int_en_q)
    );

    leaf_irq_mask #(.W(EVT_W), .RST(HEN_RST)) u_halt_en (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i && hit_hen),
        .wdata_i (cfg_wdata_i[EVT_W-1:0]),
        .en_o    (halt_en_q)
    );

    leaf_irq_reduce #(.W(EVT_W)) u_reduce (
        .src_i     (evt_q),
        .int_en_i  (int_en_q),
        .halt_en_i (halt_en_q),
        .irq_o     (irq_o),
        .halt_o    (halt_o)
    );

    always_comb begin
        cfg_rdata_o = '0;
        if (hit_stat) begin
            cfg_rdata_o[EVT_W-1:0]     = evt_q;
            cfg_rdata_o[ID_LSB +: ID_W] = id_q;
        end else if (hit_ien) begin
            cfg_rdata_o[EVT_W-1:0] = int_en_q;
        end else if (hit_hen) begin
            cfg_rdata_o[EVT_W-1:0] = halt_en_q;
        end
    end
endmodule

// File: rtl/leaf_irq_unit_chk.sv
module leaf_irq_unit_chk
    import leaf_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int ID_W   = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              ecc_err_i,
    input logic [ID_W-1:0]   bus_master_i,
    input logic [EVT_W-1:0]  evt_set,
    input logic [EVT_W-1:0]  evt_clr,
    input logic              id_clr,
    input logic              cfg_we_i,
    input logic [ADDR_W-1:0] cfg_addr_i,
    input logic [DATA_W-1:0] cfg_rdata_o,
    input logic [EVT_W-1:0]  evt_q,
    input logic [ID_W-1:0]   id_q,
    input logic              held_q,
    input logic [EVT_W-1:0]  int_en_q,
    input logic [EVT_W-1:0]  halt_en_q,
    input logic              irq_o,
    input logic              halt_o
);
    for (genvar i = 0; i < EVT_W; i++) begin : g_evt
        a_r2_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
            evt_set[i] |=> evt_q[i]);
        a_r3_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (evt_clr[i] && !evt_set[i]) |=> !evt_q[i]);
        a_r3_no_touch: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!evt_clr[i] && !evt_set[i]) |=> $stable(evt_q[i]));
        a_r5_irq_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (evt_q[i] && int_en_q[i]) |-> irq_o);
        a_r6_halt_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (evt_q[i] && halt_en_q[i]) |-> halt_o);
    end

    a_r5_irq_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((evt_q & int_en_q) == '0) |-> !irq_o);
    a_r6_halt_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((evt_q & halt_en_q) == '0) |-> !halt_o);
    a_r8_id_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (held_q && !id_clr) |=> $stable(id_q));
    a_r9_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ecc_err_i && (!held_q || id_clr)) |=> (id_q == $past(bus_master_i)));
    a_r10_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_addr_i != ADDR_W'(OFS_STAT) && cfg_addr_i != ADDR_W'(OFS_IEN) &&
         cfg_addr_i != ADDR_W'(OFS_HEN)) |-> (cfg_rdata_o == '0));
    a_r10_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_addr_i != ADDR_W'(OFS_IEN) && cfg_addr_i != ADDR_W'(OFS_HEN))
        |=> ($stable(int_en_q) && $stable(halt_en_q)));
endmodule

bind leaf_irq_unit leaf_irq_unit_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ecc_err_i    (ecc_err_i),
    .bus_master_i (bus_master_i),
    .evt_set      (evt_set),
    .evt_clr      (evt_clr),
    .id_clr       (id_clr),
    .cfg_we_i     (cfg_we_i),
    .cfg_addr_i   (cfg_addr_i),
    .cfg_rdata_o  (cfg_rdata_o),
    .evt_q        (evt_q),
    .id_q         (id_q),
    .held_q       (held_q),
    .int_en_q     (int_en_q),
    .halt_en_q    (halt_en_q),
    .irq_o        (irq_o),
    .halt_o       (halt_o)
);

// File: tb/leaf_irq_unit_bench.sv
`timescale 1ns/1ps
module leaf_irq_unit_bench;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int ID_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              crc = 1'b0, len = 1'b0, ecc = 1'b0;
    logic [ID_W-1:0]   master = '0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              irq, halt;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    leaf_irq_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_leaf_irq_unit (
        .clk_i(clk), .rst_ni(rst_n),
        .crc_err_i(crc), .len_err_i(len), .ecc_err_i(ecc),
        .bus_master_i(master),
        .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
        .cfg_rdata_o(rdata), .irq_o(irq), .halt_o(halt)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input logic [2:0] ev, input logic [ID_W-1:0] m);
        crc = ev[0]; len = ev[1]; ecc = ev[2]; master = m;
        @(negedge clk);
        crc = 1'b0; len = 1'b0; ecc = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, v); check("R1 status", v, 32'h0);
        rd(4'h4, v); check("R1 int_en", v, 32'h3);
        rd(4'h8, v); check("R1 halt_en", v, 32'h4);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 halt", {31'b0, halt}, 32'h0);

        // R2 R5 R6 R7 sweep
        for (int s = 0; s < 8; s++) begin
            for (int ie = 0; ie < 8; ie++) begin
                for (int he = 0; he < 8; he++) begin
                    wr(4'h0, 32'h7);
                    wr(4'h4, 32'(ie));
                    wr(4'h8, 32'(he));
                    pulse(3'(s), 4'h1);
                    @(negedge clk);
                    rd(4'h0, v); check("R2 sticky status", v & 32'h7, 32'(s));
                    rd(4'h4, v); check("R7 int_en", v, 32'(ie));
                    rd(4'h8, v); check("R7 halt_en", v, 32'(he));
                    check("R5 irq", {31'b0, irq}, {31'b0, (s & ie) != 0});
                    check("R6 halt", {31'b0, halt}, {31'b0, (s & he) != 0});
                end
            end
        end

        // R7 upper bits
        wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, v); check("R7 ien upper", v, 32'h7);
        wr(4'h8, 32'hFFFF_FFF8); rd(4'h8, v); check("R7 hen upper", v, 32'h0);

        // R3 write-one-to-clear
        wr(4'h0, 32'hF7);
        pulse(3'b111, 4'h0);
        wr(4'h0, 32'h0);  rd(4'h0, v); check("R3 zero write", v & 32'h7, 32'h7);
        wr(4'h0, 32'h2);  rd(4'h0, v); check("R3 clear len", v & 32'h7, 32'h5);
        wr(4'h0, 32'h5);  rd(4'h0, v); check("R3 clear rest", v & 32'h7, 32'h0);

        // R4 set beats clear
        crc = 1'b1;
        wr(4'h0, 32'h1);
        crc = 1'b0;
        rd(4'h0, v); check("R4 set wins", v & 32'h7, 32'h1);

        // R8 capture and hold
        wr(4'h0, 32'hF7);
        rd(4'h0, v); check("R9 cleared", v, 32'h0);
        pulse(3'b100, 4'h9);
        rd(4'h0, v); check("R8 captured", v, 32'h94);
        pulse(3'b100, 4'h3);
        rd(4'h0, v); check("R8 held", v, 32'h94);

        // R9 clear and re-arm
        wr(4'h0, 32'h10);
        rd(4'h0, v); check("R9 id cleared", v, 32'h04);
        pulse(3'b100, 4'h5);
        rd(4'h0, v); check("R9 recapture", v, 32'h54);
        ecc = 1'b1; master = 4'hA;
        wr(4'h0, 32'h80);
        ecc = 1'b0;
        rd(4'h0, v); check("R9 same cycle capture", v, 32'hA4);

        // R11 id does not drive outputs
        wr(4'h0, 32'h7);
        wr(4'h4, 32'h7);
        wr(4'h8, 32'h7);
        rd(4'h0, v); check("R11 status", v, 32'hA0);
        check("R11 irq", {31'b0, irq}, 32'h0);
        check("R11 halt", {31'b0, halt}, 32'h0);

        // R10 unmapped offsets
        for (int a = 0; a < 16; a++) begin
            if (a != 0 && a != 4 && a != 8) begin
                wr(4'(a), 32'h0);
                rd(4'(a), v); check("R10 unmapped read", v, 32'h0);
            end
        end
        wr(4'hC, 32'hFFFF_FFFF);
        wr(4'h5, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R10 status kept", v, 32'hA0);
        rd(4'h4, v); check("R10 ien kept", v, 32'h7);
        rd(4'h8, v); check("R10 hen kept", v, 32'h7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule